// File: doc/BRIEF.md
# Addressable Toggle Scan Cell Array

This block is a square array of state flip-flops that live in a functional datapath and double as random-access test cells. In normal operation every cell loads its bit of a functional data vector whenever the functional clock enable is high. For test, a single cell is picked by a binary address and inverted in place. The array has no serial scan-in wire and no mode wire reaching the cells. Each cell works out what to do from two decoded select lines and its clock qualifier.

The address is split into a row half (upper bits) and a column half (lower bits). Each half goes through its own one-hot decoder, and both decoders are enabled only by the test-write strobe. A cell with both of its lines high toggles. A cell with neither line high follows the functional clock. A cell with exactly one line high is not clocked. While a write is in progress the functional clock qualifier is withheld, so a write changes exactly one bit. The state vector is the cell registers themselves.

Top module: `toggle_scan_grid`

## Requirements
- R1: A synchronous active-high reset clears every bit of `state_q` to 0 at the next clock edge. Reset takes priority over any write or functional load in the same cycle.
- R2: When `func_en` and `test_wr` are both low, `state_q` keeps its value at the clock edge, whatever `func_d` is.
- R3: When `func_en` is high and `test_wr` is low, `state_q` takes the value of `func_d` at the clock edge.
- R4: When `test_wr` is high, bit `state_q[addr]` is inverted at the clock edge. The upper half of `addr` selects the row and the lower half selects the column, so the bit index is row*SIDE+column, which equals `addr`.
- R5: When `test_wr` is high, every bit other than `state_q[addr]` keeps its value, even if `func_en` is high and `func_d` differs.
- R6: Two writes in a row to the same address bring the cell back to its original value.
- R7: Any sequence of writes and functional loads matches a bit-level reference model after every cycle, and this holds for all N addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_en | input | 1 | Functional clock enable |
| test_wr | input | 1 | Test-write strobe that toggles the addressed cell |
| addr | input | log2(N) | Cell address: row in the upper half, column in the lower half |
| func_d | input | N | Functional data vector |
| state_q | output | N | Cell state vector |

## Verification
A functional load and a test write can be requested in the same cycle. The bench drives `func_en` high with `func_d` set to the inverse of the expected state while `test_wr` targets one address, so a load that leaked through would be seen at once. The result is judged against a reference that flips only the addressed bit and holds the other bits. Reset is also asserted on top of a write to confirm that reset wins.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_TOGGLE  = 2'd2
  } cell_mode_e;

  // Mode comes only from the two select lines and the clock qualifier.
  function automatic cell_mode_e mode_of(input logic fclk, input logic x, input logic y);
    if (x && y)              return MODE_TOGGLE;
    else if (!x && !y && fclk) return MODE_CAPTURE;
    else                     return MODE_HOLD;
  endfunction

endpackage

// File: rtl/tsg_decoder.sv
module tsg_decoder #(
  parameter int IN_W  = 2,
  parameter int OUT_W = 1 << IN_W
) (
  input  logic             en,
  input  logic [IN_W-1:0]  code,
  output logic [OUT_W-1:0] lines
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    assign lines[i] = en && (code == IN_W'(i));
  end

endmodule

// File: rtl/tsg_cell.sv
module tsg_cell
  import tsg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fclk,
  input  logic x,
  input  logic y,
  input  logic d,
  output logic q
);

  cell_mode_e mode;

  always_comb mode = mode_of(fclk, x, y);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      case (mode)
        MODE_TOGGLE:  q <= ~q;
        MODE_CAPTURE: q <= d;
        default:      q <= q;
      endcase
    end
  end

endmodule

// File: rtl/toggle_scan_grid.sv
module toggle_scan_grid #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 func_en,
  input  logic                 test_wr,
  input  logic [$clog2(N)-1:0] addr,
  input  logic [N-1:0]         func_d,
  output logic [N-1:0]         state_q
);

  localparam int ADDR_W = $clog2(N);
  localparam int HALF_W = ADDR_W / 2;
  localparam int SIDE   = 1 << HALF_W;

  logic [SIDE-1:0] row_ln;
  logic [SIDE-1:0] col_ln;
  logic            fclk;

  // The functional clock is withheld while a test write is in progress.
  assign fclk = func_en && !test_wr;

  tsg_decoder #(.IN_W(HALF_W), .OUT_W(SIDE)) u_row (
    .en    (test_wr),
    .code  (addr[ADDR_W-1:HALF_W]),
    .lines (row_ln)
  );

  tsg_decoder #(.IN_W(HALF_W), .OUT_W(SIDE)) u_col (
    .en    (test_wr),
    .code  (addr[HALF_W-1:0]),
    .lines (col_ln)
  );

  for (genvar r = 0; r < SIDE; r++) begin : g_row
    for (genvar c = 0; c < SIDE; c++) begin : g_col
      tsg_cell u_cell (
        .clk  (clk),
        .rst  (rst),
        .fclk (fclk),
        .x    (row_ln[r]),
        .y    (col_ln[c]),
        .d    (func_d[r*SIDE+c]),
        .q    (state_q[r*SIDE+c])
      );
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> state_q == '0); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!func_en && !test_wr) |=> $stable(state_q)); // R2
  AST_FUNC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (func_en && !test_wr) |=> state_q == $past(func_d)); // R3
  AST_ONE_BIT_FLIPS: assert property (@(posedge clk) disable iff (rst)
    test_wr |=> $countones(state_q ^ $past(state_q)) == 1); // R5
  AST_ADDR_BIT_FLIPS: assert property (@(posedge clk) disable iff (rst)
    test_wr |=> state_q[$past(addr)] != $past(state_q[addr])); // R4
  AST_DEC_SELECT: assert property (@(posedge clk) disable iff (rst)
    test_wr |-> ($countones(row_ln) == 1 && $countones(col_ln) == 1)); // R4
  AST_DEC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !test_wr |-> (row_ln == '0 && col_ln == '0)); // R3

endmodule

// File: tb/sim_toggle_scan_grid.sv
`timescale 1ns/1ps
module sim_toggle_scan_grid;

  localparam int N = 16;
  localparam int AW = $clog2(N);

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          func_en = 1'b0;
  logic          test_wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  func_d = '0;
  logic [N-1:0]  state_q;

  logic [N-1:0]  model = '0;
  item_t         sb[$];
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  toggle_scan_grid #(.N(N)) u0 (
    .clk(clk), .rst(rst), .func_en(func_en), .test_wr(test_wr),
    .addr(addr), .func_d(func_d), .state_q(state_q)
  );

  task automatic step(input logic r, input logic fe, input logic tw,
                      input logic [AW-1:0] a, input logic [N-1:0] d, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; func_en = fe; test_wr = tw; addr = a; func_d = d;
    if (r) model = '0;
    else if (tw) model[a] = ~model[a];
    else if (fe) model = d;
    it.exp = model;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare one item per clock edge, shortly after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (state_q !== it.exp) begin
          errors++;
          $display("FAIL %s: state_q=%h expected=%h", it.tag, state_q, it.exp);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, 16'hffff, "R1 reset");
    step(1, 1, 1, 3, 16'hffff, "R1 reset");
    step(0, 1, 0, 0, 16'ha5a5, "R3 load");
    step(0, 1, 0, 0, 16'h3c96, "R3 load");
    step(0, 0, 0, 0, 16'hffff, "R2 hold");
    step(0, 0, 0, 7, 16'h0000, "R2 hold");
    step(0, 0, 1, 0, 16'h0000, "R4 write addr 0");
    step(0, 0, 1, 15, 16'h0000, "R4 write addr 15");
    step(0, 0, 1, 6, 16'h0000, "R4 write addr 6 row1 col2");
    step(0, 0, 1, 9, 16'h0000, "R4 write addr 9 row2 col1");
    step(0, 1, 1, 4, ~model, "R5 write with load");
    step(0, 1, 1, 11, ~model, "R5 write with load");
    step(0, 0, 1, 13, 16'h0000, "R6 first write");
    step(0, 0, 1, 13, 16'h0000, "R6 second write");
    step(0, 1, 0, 0, 16'h0000, "R3 load zero");
    for (int i = 0; i < N; i++) begin
      step(0, 0, 1, AW'(i), 16'h0000, "R7 sweep write");
      if (i % 4 == 3) step(0, 1, 0, 0, 16'h1234 ^ N'(i * 16'h0f0f), "R7 sweep load");
    end
    for (int i = N - 1; i >= 0; i--) step(0, (i % 2) == 0, 1, AW'(i), 16'hc33c, "R7 sweep write");
    step(0, 0, 0, 2, 16'h5555, "R2 hold");
    step(1, 0, 1, 5, 16'h0000, "R1 reset over write");
    step(0, 0, 0, 0, 16'h0000, "R2 hold after reset");
    @(negedge clk);
    rst = 0; func_en = 0; test_wr = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule